// File: doc/BRIEF.md
# Guarded Configuration Byte Writer

This block sits between a CPU-side register bus and a small nonvolatile configuration store, modelled here as a byte array that comes out of reset fully erased (every bit 1). Software loads a 24-bit table pointer and a data byte, then opens a write by writing the two key bytes 55h and AAh to a key register. Only then does a control write that sets the start bit program the addressed byte. The control write must also select program memory, select configuration space and set the write-enable bit.

A write that is accepted stalls the requester for a fixed number of clock cycles, which stands in for the timed programming cycle. When that time ends, the block clears the start bit itself. A start request that fails any condition leaves the store untouched and sets a sticky error flag. The block does not control interrupts. It only raises a fault output when interrupts are reported enabled while a key sequence or a write cycle is in progress.

Top module: `cfg_byte_writer`

## Requirements
- R1: After reset, `stall` is 0, `ctrl_rdata` is 00h, `irq_fault` is 0 and every byte of the store reads FFh.
- R2: The `reg_sel` codes are 0 = pointer bits 7:0, 1 = pointer bits 15:8, 2 = pointer bits 23:16, 3 = data latch, 4 = control, 5 = key. `tbl_rdata` returns the store byte at the pointer when the pointer lies in 300000h to 300000h+NUM_BYTES-1, and 00h for any other pointer.
- R3: A control write is accepted when all of these hold:
  - bit 1 (start) is 1;
  - bit 7 (program memory select), bit 6 (configuration select) and bit 2 (write enable) are all 1;
  - the pointer is in range;
  - the two bus writes just before it were 55h and then AAh to the key register.
  An accepted write stores the data latch into exactly the pointed byte.
- R4: After an accepted start, `stall` is high for exactly WRITE_CYCLES cycles, beginning the cycle after the control write. Control bit 1 reads 1 while `stall` is high and 0 once it drops.
- R5: Any of the following leaves the block unlocked, so a following start is refused:
  - a key write that is not the expected next byte;
  - any other bus write between the key writes;
  - any other bus write between the second key write and the start.
- R6: A refused start leaves the store unchanged, sets the error bit (control bit 3) and does not raise `stall`. A start is refused for a missing unlock, for write enable, program memory select or configuration select being 0, or for a pointer out of range.
- R7: The error bit is sticky. A control write with bit 3 = 1 keeps it. Only a control write with bit 3 = 0 clears it.
- R8: Every bus write made while `stall` is high is ignored, including pointer, data, key and control writes.
- R9: `irq_fault` is 1 exactly when `irq_en` is 1 and either a key sequence is partly entered or `stall` is high.
- R10: A control write with bit 1 = 0 only updates bits 7, 6 and 2. It raises no error and starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| bus_wdata | input | 8 | Write data |
| irq_en | input | 1 | CPU reports interrupts enabled |
| tbl_rdata | output | 8 | Store byte at the table pointer |
| ctrl_rdata | output | 8 | Control register readback |
| stall | output | 1 | Requester stall during a write cycle |
| irq_fault | output | 1 | Interrupts enabled during a guarded operation |

## Verification
The assertions check on every cycle that:
- a stall run lasts exactly the write time and is never longer;
- a stall starts only after a control write with the start bit set;
- the start bit mirrors the stall;
- the error bit falls only on a clearing control write;
- the interrupt fault covers the whole stall.

Only the bench scenarios can show the other behaviours:
- which byte changed and that all the others stayed put;
- that broken, reordered or interrupted key sequences are refused;
- that writes issued during the stall leave no trace afterwards.

// File: rtl/cfg_byte_writer.sv
module cfg_byte_writer #(
  parameter int          NUM_BYTES    = 16,
  parameter int          WRITE_CYCLES = 80000,
  parameter logic [23:0] CFG_BASE     = 24'h300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] reg_sel,
  input  logic [7:0] bus_wdata,
  input  logic       irq_en,
  output logic [7:0] tbl_rdata,
  output logic [7:0] ctrl_rdata,
  output logic       stall,
  output logic       irq_fault
);
  localparam int          IW    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int          CW    = $clog2(WRITE_CYCLES + 1);
  localparam logic [24:0] LIMIT = {1'b0, CFG_BASE} + 25'(NUM_BYTES);

  localparam logic [2:0] SEL_PLO = 3'd0, SEL_PMID = 3'd1, SEL_PHI = 3'd2,
                         SEL_DATA = 3'd3, SEL_CTRL = 3'd4, SEL_KEY = 3'd5;

  typedef enum logic [1:0] {U_IDLE, U_HALF, U_ARMED} ustate_t;

  ustate_t       ustate;
  logic [23:0]   ptr;
  logic [7:0]    dlat;
  logic          mem_sel, cfg_sel, wen, start_bit, err, busy;
  logic [CW-1:0] cnt;
  logic [7:0]    store [NUM_BYTES];

  logic          acc, ctrl_wr, go_req, go_ok, in_range;
  logic [IW-1:0] idx;

  assign acc      = bus_wr && !busy;
  assign in_range = (ptr[23:20] == 4'h3) && (ptr >= CFG_BASE) && ({1'b0, ptr} < LIMIT);
  assign idx      = IW'(ptr - CFG_BASE);
  assign ctrl_wr  = acc && (reg_sel == SEL_CTRL);
  assign go_req   = ctrl_wr && bus_wdata[1];
  assign go_ok    = go_req && (ustate == U_ARMED) && bus_wdata[7] && bus_wdata[6]
                    && bus_wdata[2] && in_range;

  assign tbl_rdata  = in_range ? store[idx] : 8'h00;
  assign ctrl_rdata = {mem_sel, cfg_sel, 2'b00, err, wen, start_bit, 1'b0};
  assign stall      = busy;
  assign irq_fault  = irq_en && ((ustate != U_IDLE) || busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ustate <= U_IDLE;
    end else if (acc) begin
      if (reg_sel == SEL_KEY) begin
        if (ustate == U_IDLE && bus_wdata == 8'h55)      ustate <= U_HALF;
        else if (ustate == U_HALF && bus_wdata == 8'hAA) ustate <= U_ARMED;
        else                                             ustate <= U_IDLE;
      end else begin
        ustate <= U_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      dlat <= '0;
    end else if (acc) begin
      case (reg_sel)
        SEL_PLO:  ptr[7:0]   <= bus_wdata;
        SEL_PMID: ptr[15:8]  <= bus_wdata;
        SEL_PHI:  ptr[23:16] <= bus_wdata;
        SEL_DATA: dlat       <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel   <= 1'b0;
      cfg_sel   <= 1'b0;
      wen       <= 1'b0;
      start_bit <= 1'b0;
      err       <= 1'b0;
    end else if (ctrl_wr) begin
      mem_sel   <= bus_wdata[7];
      cfg_sel   <= bus_wdata[6];
      wen       <= bus_wdata[2];
      start_bit <= go_ok;
      err       <= (err && bus_wdata[3]) || (go_req && !go_ok);
    end else if (busy && cnt == '0) begin
      start_bit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go_ok) begin
      busy <= 1'b1;
      cnt  <= CW'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) store[i] <= 8'hFF;
    end else if (go_ok) begin
      store[idx] <= dlat;
    end
  end
endmodule

module cfg_byte_writer_chk #(
  parameter int WRITE_CYCLES = 80000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [2:0] reg_sel,
  input logic [7:0] bus_wdata,
  input logic       irq_en,
  input logic [7:0] ctrl_rdata,
  input logic       stall,
  input logic       irq_fault
);
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= stall ? run + 1 : '0;
  end

  // R4
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> run == WRITE_CYCLES);

  // R4
  stall_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> run < WRITE_CYCLES);

  // R4
  start_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[1] == stall);

  // R3
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(bus_wr && reg_sel == 3'd4 && bus_wdata[1]));

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rdata[3]) |-> $past(bus_wr && reg_sel == 3'd4 && !bus_wdata[3] && !stall));

  // R9
  irq_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && stall) |-> irq_fault);
endmodule

bind cfg_byte_writer cfg_byte_writer_chk #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .reg_sel(reg_sel),
  .bus_wdata(bus_wdata), .irq_en(irq_en), .ctrl_rdata(ctrl_rdata),
  .stall(stall), .irq_fault(irq_fault)
);

// File: tb/cfg_byte_writer_test.sv
module cfg_byte_writer_test;
  localparam int NB = 16;
  localparam int W  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic       irq_en = 1'b0;
  logic [7:0] tbl_rdata, ctrl_rdata;
  logic       stall, irq_fault;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  logic [7:0] model [NB];

  always #2.5 clk = ~clk;

  cfg_byte_writer #(.NUM_BYTES(NB), .WRITE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .reg_sel(reg_sel),
    .bus_wdata(bus_wdata), .irq_en(irq_en), .tbl_rdata(tbl_rdata),
    .ctrl_rdata(ctrl_rdata), .stall(stall), .irq_fault(irq_fault)
  );

  // {ptr_lo, data, key1, key2, ctrl, ok}
  localparam logic [47:0] VEC [9] = '{
    48'h00_A5_55_AA_C6_01,
    48'h0F_3C_55_AA_C6_01,
    48'h05_00_55_AA_C2_00,
    48'h05_11_55_AB_C6_00,
    48'h05_22_AA_55_C6_00,
    48'h05_33_55_AA_46_00,
    48'h05_44_55_AA_86_00,
    48'h10_55_55_AA_C6_00,
    48'h07_5A_55_AA_C6_01
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; reg_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [23:0] p);
    wr(3'd2, p[23:16]); wr(3'd1, p[15:8]); wr(3'd0, p[7:0]);
  endtask

  task automatic check_store(input string req);
    int bad = 0;
    logic [7:0] a = 0, e = 0;
    for (int i = 0; i < NB; i++) begin
      set_ptr(24'h300000 + 24'(i));
      if (tbl_rdata !== model[i] && bad == 0) begin bad = 1; a = tbl_rdata; e = model[i]; end
    end
    chk(bad == 0, req, a, e);
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall === 1'b1 && n < 4 * W) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stall === 1'b0, "R1 stall", stall, 0);
    chk(ctrl_rdata === 8'h00, "R1 ctrl", ctrl_rdata, 0);
    chk(irq_fault === 1'b0, "R1 irq_fault", irq_fault, 0);
    check_store("R1 erased store");

    for (int v = 0; v < 9; v++) begin
      logic [47:0] t = VEC[v];
      set_ptr({16'h3000, t[47:40]});
      wr(3'd3, t[39:32]);
      wr(3'd4, 8'h00);
      wr(3'd5, t[31:24]);
      wr(3'd5, t[23:16]);
      wr(3'd4, t[15:8]);
      chk(stall === t[0], "R3 stall on start", stall, t[0]);
      chk(ctrl_rdata[3] === !t[0], "R6 error flag", ctrl_rdata[3], !t[0]);
      if (t[0]) begin
        chk(ctrl_rdata[1] === 1'b1, "R4 start bit during write", ctrl_rdata[1], 1);
        count_stall(n);
        chk(n == W, "R4 stall length", n, W);
        chk(ctrl_rdata[1] === 1'b0, "R4 start bit cleared", ctrl_rdata[1], 0);
        model[t[43:40]] = t[39:32];
        check_store("R3 single byte written");
      end else begin
        check_store("R6 store unchanged");
      end
    end

    // R5 intervening access between key writes
    wr(3'd4, 8'h00);
    set_ptr(24'h300004); wr(3'd3, 8'h66);
    wr(3'd5, 8'h55); wr(3'd3, 8'h66); wr(3'd5, 8'hAA); wr(3'd4, 8'hC6);
    chk(stall === 1'b0 && ctrl_rdata[3] === 1'b1, "R5 access between keys", {stall, ctrl_rdata[3]}, 2'b01);
    // R5 intervening access after second key
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h55); wr(3'd5, 8'hAA); wr(3'd4, 8'hC4); wr(3'd4, 8'hC6);
    chk(stall === 1'b0 && ctrl_rdata[3] === 1'b1, "R5 access before start", {stall, ctrl_rdata[3]}, 2'b01);
    check_store("R5 store unchanged");

    // R7 sticky error
    wr(3'd4, 8'h08);
    chk(ctrl_rdata[3] === 1'b1, "R7 error kept", ctrl_rdata[3], 1);
    wr(3'd4, 8'h00);
    chk(ctrl_rdata[3] === 1'b0, "R7 error cleared", ctrl_rdata[3], 0);

    // R10 control write without start
    wr(3'd4, 8'hC4);
    chk(ctrl_rdata === 8'hC4 && stall === 1'b0, "R10 plain control write", ctrl_rdata, 8'hC4);

    // R8 writes during stall ignored
    set_ptr(24'h300002); wr(3'd3, 8'h77);
    wr(3'd5, 8'h55); wr(3'd5, 8'hAA); wr(3'd4, 8'hC6);
    model[2] = 8'h77;
    wr(3'd3, 8'h99); wr(3'd0, 8'h03); wr(3'd4, 8'h00);
    wr(3'd5, 8'h55); wr(3'd5, 8'hAA);
    chk(ctrl_rdata === 8'hC6, "R8 control held during stall", ctrl_rdata, 8'hC6);
    count_stall(n);
    chk(tbl_rdata === 8'h77, "R8 pointer unchanged", tbl_rdata, 8'h77);
    wr(3'd4, 8'hC6);
    chk(stall === 1'b0 && ctrl_rdata[3] === 1'b1, "R8 keys during stall ignored", {stall, ctrl_rdata[3]}, 2'b01);
    check_store("R8 store");

    // R2 read outside range
    set_ptr(24'h200000);
    chk(tbl_rdata === 8'h00, "R2 read out of range", tbl_rdata, 0);
    set_ptr(24'h300010);
    chk(tbl_rdata === 8'h00, "R2 read past last byte", tbl_rdata, 0);
    set_ptr(24'h30000F);
    chk(tbl_rdata === model[15], "R2 read in range", tbl_rdata, model[15]);

    // R9 interrupt fault
    irq_en = 1'b1;
    wr(3'd5, 8'h55);
    chk(irq_fault === 1'b1, "R9 fault during key entry", irq_fault, 1);
    wr(3'd3, 8'h01);
    chk(irq_fault === 1'b0, "R9 fault clears with sequence", irq_fault, 0);
    irq_en = 1'b0;
    wr(3'd5, 8'h55); wr(3'd5, 8'hAA); wr(3'd4, 8'hC6);
    chk(irq_fault === 1'b0, "R9 no fault when disabled", irq_fault, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq_fault === 1'b1 && stall === 1'b1, "R9 fault during stall", irq_fault, 1);
    irq_en = 1'b0;
    count_stall(n);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule